// File: doc/BRIEF.md
# Lockable RAM Window Guard

This block sits on the path from a host byte-access port to a battery-backed RAM of 256 bytes. Two fixed 8-byte windows in that space can each be hidden from the host. Window 0 covers addresses 38h to 3Fh. Window 1 covers F8h to FFh. Each window has its own lock bit.

While a window is locked, host writes into it never reach the RAM. Host reads from it return the filler byte FFh, and the RAM is not accessed at all. Addresses outside a locked window pass through unchanged. The lock bits sit in a small configuration register that the host can only set. Once set, a bit stays set until reset.

All outputs are registered. The RAM side expects a synchronous single-port memory with one cycle of read latency. A read request therefore returns its byte on the host port three clock cycles after the request is sampled.

Top module: `ram_lock_guard`

## Requirements
- R1: During and after reset, `lock_state` is 00b, `host_rvalid` is 0, and `ram_en` and `ram_we` are 0.
- R2: An access that is not blocked is forwarded to the RAM port one cycle after the request is sampled, with the same address and write data. `ram_we` is 1 only for writes. A read returns the RAM byte on `host_rdata`, with `host_rvalid` high, three cycles after the request is sampled. Writes produce no `host_rvalid`.
- R3: Window 0 spans addresses 38h to 3Fh and is locked by `lock_state` bit 0. Window 1 spans F8h to FFh and is locked by bit 1.
- R4: A write to an address in a locked window raises neither `ram_en` nor `ram_we`. The stored byte keeps its earlier value.
- R5: A read from an address in a locked window returns FFh, with the same latency as a normal read, and raises no `ram_en`.
- R6: A configuration write ORs `cfg_wdata` into `lock_state`. A 0 in `cfg_wdata` never clears a bit. `lock_state` changes only in the cycle after a configuration write.
- R7: A set lock bit stays set until reset. Reset clears it.
- R8: A host request is judged against the lock bits held before the clock edge that samples it. A configuration write sampled on that same edge affects only later requests.
- R9: Locking one window has no effect on the other window or on addresses just outside a window (37h, 40h, F7h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte returned to the host |
| host_rvalid | output | 1 | `host_rdata` is valid this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Lock bits to set (bit i sets window i) |
| lock_state | output | 2 | Current lock bits |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after `ram_en` |

## Verification
Each address is written with a byte derived from that address, so any address-decode slip or data mix-up shows up as a wrong value on read-back. Reads and writes are tried at the first and last byte of each window and at the neighbouring bytes 37h, 40h and F7h, with one window locked and then both, which separates a correct window decode from one that is too wide or too narrow. A lock set on the same edge as a read tells apart locks evaluated before the edge from locks evaluated after it. A reset after a dropped write separates a write that was truly blocked from one that was only hidden by the filler value on read.

// File: rtl/lkg_pkg.sv
package lkg_pkg;

  // Classification of one host request after lock evaluation
  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_READ    = 3'd1,
    ACC_WRITE   = 3'd2,
    ACC_DROP_WR = 3'd3,
    ACC_FILL_RD = 3'd4
  } acc_kind_e;

endpackage

// File: rtl/lkg_win_decode.sv
module lkg_win_decode #(
  parameter int ADDR_W  = 8,
  parameter int NUM_WIN = 2,
  parameter int WIN_LG  = 3,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {8'hF8, 8'h38}
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_WIN-1:0] hit
);

  localparam int TAG_W = ADDR_W - WIN_LG;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = WIN_BASES[w*ADDR_W +: ADDR_W];
    localparam logic [TAG_W-1:0]  TAG  = BASE[ADDR_W-1:WIN_LG];
    assign hit[w] = (addr[ADDR_W-1:WIN_LG] == TAG);
  end

endmodule

// File: rtl/lkg_lock_reg.sv
module lkg_lock_reg #(
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [NUM_WIN-1:0] set_bits,
  output logic [NUM_WIN-1:0] lock
);

  logic [NUM_WIN-1:0] lock_q;

  // Set-only register: bits leave 1 only through reset
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
    end else if (set_en) begin
      lock_q <= lock_q | set_bits;
    end
  end

  assign lock = lock_q;

endmodule

// File: rtl/lkg_access_gate.sv
module lkg_access_gate
  import lkg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int NUM_WIN = 2,
  parameter logic [DATA_W-1:0] FILL_VAL = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_WIN-1:0] hit,
  input  logic [NUM_WIN-1:0] lock,
  output logic               ram_en,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid
);

  acc_kind_e   kind;
  logic        blocked;

  logic              en_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd1_q, fill1_q, rd2_q, fill2_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign blocked = |(hit & lock);

  always_comb begin
    kind = ACC_NONE;
    if (req) begin
      if (blocked) kind = we ? ACC_DROP_WR : ACC_FILL_RD;
      else         kind = we ? ACC_WRITE   : ACC_READ;
    end
  end

  // Stage 1: RAM request
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd1_q   <= 1'b0;
      fill1_q <= 1'b0;
    end else begin
      en_q    <= (kind == ACC_READ) || (kind == ACC_WRITE);
      we_q    <= (kind == ACC_WRITE);
      rd1_q   <= (kind == ACC_READ);
      fill1_q <= (kind == ACC_FILL_RD);
      if ((kind == ACC_READ) || (kind == ACC_WRITE)) begin
        addr_q  <= addr;
        wdata_q <= wdata;
      end
    end
  end

  // Stage 2: RAM read in flight; stage 3: registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rd2_q    <= 1'b0;
      fill2_q  <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rd2_q    <= rd1_q;
      fill2_q  <= fill1_q;
      rvalid_q <= rd2_q | fill2_q;
      if (rd2_q || fill2_q) begin
        rdata_q <= fill2_q ? FILL_VAL : ram_rdata;
      end
    end
  end

  assign ram_en    = en_q;
  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;
  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;

endmodule

// File: rtl/ram_lock_guard.sv
module ram_lock_guard #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int NUM_WIN = 2,
  parameter int WIN_LG  = 3,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {8'hF8, 8'h38},
  parameter logic [DATA_W-1:0] FILL_VAL = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  input  logic               cfg_we,
  input  logic [NUM_WIN-1:0] cfg_wdata,
  output logic [NUM_WIN-1:0] lock_state,
  output logic               ram_en,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata
);

  logic [NUM_WIN-1:0] win_hit;
  logic [NUM_WIN-1:0] lock_bits;

  lkg_win_decode #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LG(WIN_LG), .WIN_BASES(WIN_BASES)
  ) u_decode (
    .addr (host_addr),
    .hit  (win_hit)
  );

  lkg_lock_reg #(.NUM_WIN(NUM_WIN)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .set_en   (cfg_we),
    .set_bits (cfg_wdata),
    .lock     (lock_bits)
  );

  lkg_access_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .FILL_VAL(FILL_VAL)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .req       (host_req),
    .we        (host_we),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .hit       (win_hit),
    .lock      (lock_bits),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .rdata     (host_rdata),
    .rvalid    (host_rvalid)
  );

  assign lock_state = lock_bits;

endmodule

// File: rtl/lkg_checker.sv
module lkg_checker #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int NUM_WIN = 2,
  parameter int WIN_LG  = 3,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {8'hF8, 8'h38},
  parameter logic [DATA_W-1:0] FILL_VAL = 8'hFF
) (
  input logic               clk,
  input logic               rst,
  input logic               host_req,
  input logic               host_we,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               host_rvalid,
  input logic               cfg_we,
  input logic [NUM_WIN-1:0] lock_state,
  input logic               ram_en,
  input logic               ram_we,
  input logic [ADDR_W-1:0]  ram_addr,
  input logic [DATA_W-1:0]  ram_wdata
);

  function automatic logic [NUM_WIN-1:0] in_win(input logic [ADDR_W-1:0] a);
    logic [NUM_WIN-1:0] r;
    for (int w = 0; w < NUM_WIN; w++) begin
      r[w] = (a >= WIN_BASES[w*ADDR_W +: ADDR_W]) &&
             (a <= WIN_BASES[w*ADDR_W +: ADDR_W] + ADDR_W'((1 << WIN_LG) - 1));
    end
    return r;
  endfunction

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (lock_state == '0 && !host_rvalid && !ram_en && !ram_we));

  p_fwd_write_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_en && $past(host_req && host_we) &&
                ram_addr == $past(host_addr) && ram_wdata == $past(host_wdata)));

  p_rvalid_src_r2: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(host_req && !host_we, 3));

  p_no_locked_ram_r4: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> ((in_win(ram_addr) & $past(lock_state)) == '0));

  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid && ((in_win($past(host_addr, 3)) & $past(lock_state, 3)) != '0))
      |-> host_rdata == FILL_VAL);

  p_only_cfg_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_state) |-> $past(cfg_we));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_state & $past(lock_state)) == $past(lock_state));

endmodule

bind ram_lock_guard lkg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .WIN_LG(WIN_LG),
  .WIN_BASES(WIN_BASES), .FILL_VAL(FILL_VAL)
) u_lkg_checker (
  .clk         (clk),
  .rst         (rst),
  .host_req    (host_req),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .cfg_we      (cfg_we),
  .lock_state  (lock_state),
  .ram_en      (ram_en),
  .ram_we      (ram_we),
  .ram_addr    (ram_addr),
  .ram_wdata   (ram_wdata)
);

// File: tb/test_ram_lock_guard.sv
`timescale 1ns/1ps
module test_ram_lock_guard;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_req = 1'b0, host_we = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = '0;
  logic [1:0] lock_state;
  logic       ram_en, ram_we;
  logic [7:0] ram_addr, ram_wdata;
  logic [7:0] ram_rdata;

  always #4 clk = ~clk;

  ram_lock_guard i_ram_lock_guard (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .lock_state(lock_state),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // Synchronous RAM model, not reset
  logic [7:0] mem [256];
  logic [7:0] mem_q = '0;
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        mem_q <= mem[ram_addr];
    end
  end
  assign ram_rdata = mem_q;

  int cyc = 0;
  int en_count = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (ram_en) en_count <= en_count + 1;

  typedef struct {
    logic [7:0] data;
    int         due;
    string      tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (sb.size() == 0) begin
        chk(0, "R2 unexpected rvalid", host_rdata, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(host_rdata == e.data, {e.tag, " data"}, host_rdata, e.data);
        chk(cyc == e.due, {e.tag, " latency"}, cyc, e.due);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag,
                    input bit with_cfg = 0, input logic [1:0] cfg_bits = '0);
    exp_t e;
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = a;
    if (with_cfg) begin cfg_we = 1; cfg_wdata = cfg_bits; end
    e.data = exp; e.due = cyc + 3; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    host_req = 0; cfg_we = 0;
  endtask

  task automatic cfg(input logic [1:0] bits);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = bits;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    idle(3);
    rst = 0;
  endtask

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  logic [7:0] addrs [10] = '{8'h00, 8'h37, 8'h38, 8'h3A, 8'h3F,
                             8'h40, 8'hF7, 8'hF8, 8'hFC, 8'hFF};

  initial begin
    int snap;
    idle(3);
    // R1: reset state
    chk(lock_state == 2'b00, "R1 lock_state", lock_state, 0);
    chk(!host_rvalid && !ram_en && !ram_we, "R1 outputs idle",
        {host_rvalid, ram_en, ram_we}, 0);
    rst = 0;

    // R2/R3: unlocked pass-through at window edges and neighbours
    for (int i = 0; i < 10; i++) wr(addrs[i], pat(addrs[i]));
    for (int i = 0; i < 10; i++) rd(addrs[i], pat(addrs[i]), "R2 unlocked read");
    wr(8'h3C, pat(8'h3C));
    idle(5);

    // R8: lock set on the same edge as a read does not affect that read
    rd(8'h3A, pat(8'h3A), "R8 same-edge read", 1, 2'b01);
    rd(8'h3A, 8'hFF, "R8 next read locked");
    idle(5);
    chk(lock_state == 2'b01, "R6 set bit0", lock_state, 1);

    // R4/R5: locked window 0, no RAM access
    snap = en_count;
    rd(8'h38, 8'hFF, "R5 locked read 38");
    rd(8'h3F, 8'hFF, "R5 locked read 3F");
    wr(8'h3C, 8'h00);
    idle(5);
    chk(en_count == snap, "R4 R5 no ram_en in locked window", en_count, snap);

    // R9: neighbours and other window unaffected
    rd(8'h37, pat(8'h37), "R9 read 37");
    rd(8'h40, pat(8'h40), "R9 read 40");
    rd(8'hF8, pat(8'hF8), "R9 read F8 other window");
    rd(8'hFF, pat(8'hFF), "R9 read FF other window");
    wr(8'h40, 8'h11);
    rd(8'h40, 8'h11, "R9 write 40 lands");
    idle(5);

    // R6: zeros never clear; set window 1
    cfg(2'b00);
    chk(lock_state == 2'b01, "R6 zero write keeps", lock_state, 1);
    cfg(2'b10);
    chk(lock_state == 2'b11, "R6 OR set bit1", lock_state, 3);
    rd(8'hF8, 8'hFF, "R3 window1 F8 locked");
    rd(8'hFF, 8'hFF, "R3 window1 FF locked");
    rd(8'hF7, pat(8'hF7), "R9 read F7");
    idle(5);

    // R7: reset clears locks; R4: dropped write left RAM unchanged
    do_reset();
    idle(1);
    chk(lock_state == 2'b00, "R7 reset clears locks", lock_state, 0);
    rd(8'h3C, pat(8'h3C), "R4 dropped write left 3C");
    rd(8'hFC, pat(8'hFC), "R7 window1 open after reset");
    idle(6);
    chk(sb.size() == 0, "R2 all reads answered", sb.size(), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #80000;
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule